// File: doc/BRIEF.md
# DQS Read Gate Window Generator

This block sits in the read path of a DDR3 interface and decides, for each byte lane, when the incoming DQS strobe may reach the capture logic. It is clocked at four times the DRAM clock, so one clock cycle of the block is one quarter of a DRAM cycle. When the controller issues a read, each lane waits its own programmed delay and then opens its gate. Each lane's delay comes from one byte of a packed 32-bit configuration word. The gate should open inside the read preamble and close inside the short postamble.

Two closing methods are available. In passive mode the window has a fixed length that is counted from the opening point, and the strobe is ignored. In active mode, which is the one meant for normal operation, the lane watches the DQS level. It closes the gate on the falling edge that ends the burst, and a timeout closes it if the strobe stops toggling. The delay word and the mode are loaded together, and a load is accepted only while no read is in flight. Lanes above the configured lane count are not built, and their gates stay closed.

Top module: `dqs_gate_gen`

## Requirements
- R1: After reset every gate output is 0, all lane delays are 0 and the mode is passive.
- R2: The delay of lane i is bits [8i+7:8i] of the loaded configuration word, so lane 0 uses the least significant byte.
- R3: When a read issue is sampled at clock edge E0 and a lane's delay is d, that lane's gate goes to 1 right after edge E0+d. With d = 0 this is the same edge.
- R4: In passive mode the gate stays open for exactly 16 clock cycles (one 8-beat burst in quarter-cycle units) and then closes, whatever the DQS input does.
- R5: In passive mode, a new opening point that falls while the gate is open restarts the 16-cycle count, and the gate does not drop in between.
- R6: In active mode, a DQS edge is a change of the sampled level between two consecutive clock edges. Edges are counted while the gate is open. The gate closes at the first sampled falling edge after at least 7 edges have been counted.
- R7: In active mode the gate closes after 12 consecutive open cycles in which no DQS edge is sampled.
- R8: In active mode, a new opening point while the gate is open keeps the gate open and clears both the edge count and the quiet count.
- R9: Gate outputs of lanes at or above NUM_LANES are always 0.
- R10: A load request takes the word and the mode only when, at that edge, no read issue is present, none was sampled in the previous 255 cycles, and every gate is closed. Otherwise the request has no effect.
- R11: The mode (1 = active, 0 = passive) is loaded together with the delay word and is used from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at four times the DRAM clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_issue | input | 1 | One-cycle pulse per issued read |
| cfg_word_in | input | 32 | Packed per-lane gate delays, 8 bits per lane |
| cfg_active_in | input | 1 | Mode to load: 1 active, 0 passive |
| cfg_load | input | 1 | Request to load word and mode |
| dqs_level | input | NUM_LANES | Sampled DQS level per lane |
| gate_open | output | 4 | Gate enable per lane |

## Verification
The assertions assume that `dqs_level` is a clean synchronous sample: any change between two edges counts as a strobe edge. They also assume that a load request arriving while reads are pending is meant to be dropped. In active phases the bench holds DQS low outside the bursts it schedules, and it builds each burst as a low preamble followed by whole high/low pulse pairs, sometimes cut short to trigger the timeout. In passive phases DQS is random, to show that it has no effect. Read spacing is kept wide enough that a reference list of 64 issue times covers every open window, and configuration loads are tried both while busy and after a long quiet gap.

// File: rtl/dqs_gate_pkg.sv
package dqs_gate_pkg;
  localparam int LANES_MAX = 4;
  localparam int DLY_W     = 8;
  localparam int WORD_W    = LANES_MAX * DLY_W;

  typedef logic [DLY_W-1:0] dly_t;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;

  // delay byte of one lane inside the packed word
  function automatic dly_t lane_dly(input logic [WORD_W-1:0] w, input int lane);
    return w[lane*DLY_W +: DLY_W];
  endfunction

  // edge classification from two consecutive samples
  function automatic edge_t find_edge(input logic cur, input logic prev);
    edge_t e;
    e.rise = cur & ~prev;
    e.fall = ~cur & prev;
    return e;
  endfunction
endpackage

// File: rtl/dqs_gate_hist.sv
module dqs_gate_hist #(
  parameter int DEPTH = 255
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rd_issue,
  output logic [DEPTH:0] hist,
  output logic           pending
);
  logic [DEPTH-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[DEPTH-2:0], rd_issue};
  end

  // tap k holds the issue seen k cycles ago, tap 0 the current one
  assign hist    = {sr_q, rd_issue};
  assign pending = |sr_q;

  // R3
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issue |=> hist[1]);
endmodule

// File: rtl/dqs_gate_lane.sv
module dqs_gate_lane
  import dqs_gate_pkg::*;
#(
  parameter int BURST_Q   = 16,
  parameter int EXP_EDGES = 7,
  parameter int TMO_Q     = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  input  logic dqs,
  output logic gate
);
  localparam int REM_W  = $clog2(BURST_Q + 1);
  localparam int ECNT_W = $clog2(EXP_EDGES + 1);
  localparam int IDLE_W = $clog2(TMO_Q);

  logic              open_q, open_d;
  logic [REM_W-1:0]  rem_q, rem_d;
  logic [ECNT_W-1:0] ecnt_q, ecnt_d;
  logic [IDLE_W-1:0] idle_q, idle_d;
  logic              prev_q;

  edge_t ev;
  logic  any_edge, enough, burst_end, tmo_hit, pas_last;

  assign ev        = find_edge(dqs, prev_q);
  assign any_edge  = ev.rise | ev.fall;
  assign enough    = (ecnt_q >= ECNT_W'(EXP_EDGES));
  assign burst_end = active & open_q & ev.fall & enough;
  assign tmo_hit   = active & open_q & ~any_edge & (idle_q == IDLE_W'(TMO_Q - 1));
  assign pas_last  = ~active & open_q & (rem_q <= REM_W'(1));

  always_comb begin
    open_d = open_q;
    rem_d  = rem_q;
    ecnt_d = ecnt_q;
    idle_d = idle_q;
    if (start) begin
      open_d = 1'b1;
      rem_d  = REM_W'(BURST_Q);
      ecnt_d = '0;
      idle_d = '0;
    end else if (burst_end || tmo_hit || pas_last) begin
      open_d = 1'b0;
      rem_d  = '0;
    end else if (open_q) begin
      if (active) begin
        if (any_edge) begin
          ecnt_d = enough ? ecnt_q : ecnt_q + 1'b1;
          idle_d = '0;
        end else begin
          idle_d = idle_q + 1'b1;
        end
      end else begin
        rem_d = rem_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      rem_q  <= '0;
      ecnt_q <= '0;
      idle_q <= '0;
      prev_q <= 1'b0;
    end else begin
      open_q <= open_d;
      rem_q  <= rem_d;
      ecnt_q <= ecnt_d;
      idle_q <= idle_d;
      prev_q <= dqs;
    end
  end

  assign gate = open_q;

  // R3
  open_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> gate);
  // R4
  pas_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pas_last && !start) |=> !gate);
  // R6
  act_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_end && !start) |=> !gate);
  // R7
  tmo_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_hit && !start) |=> !gate);
endmodule

// File: rtl/dqs_gate_gen.sv
module dqs_gate_gen
  import dqs_gate_pkg::*;
#(
  parameter int          NUM_LANES = 4,
  parameter int          BURST_Q   = 16,
  parameter int          EXP_EDGES = 7,
  parameter int          TMO_Q     = 12,
  parameter logic [31:0] RST_WORD  = 32'h0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_issue,
  input  logic [31:0]          cfg_word_in,
  input  logic                 cfg_active_in,
  input  logic                 cfg_load,
  input  logic [NUM_LANES-1:0] dqs_level,
  output logic [3:0]           gate_open
);
  localparam int HIST_D = (1 << DLY_W) - 1;

  logic [WORD_W-1:0] cfg_word_q;
  logic              cfg_act_q;
  logic [HIST_D:0]   hist;
  logic              pending, busy;

  dqs_gate_hist #(.DEPTH(HIST_D)) i_hist (
    .clk(clk), .rst_n(rst_n), .rd_issue(rd_issue),
    .hist(hist), .pending(pending)
  );

  assign busy = rd_issue | pending | (|gate_open);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_word_q <= RST_WORD;
      cfg_act_q  <= 1'b0;
    end else if (cfg_load && !busy) begin
      cfg_word_q <= cfg_word_in;
      cfg_act_q  <= cfg_active_in;
    end
  end

  for (genvar g = 0; g < LANES_MAX; g++) begin : g_lane
    if (g < NUM_LANES) begin : g_on
      dly_t d;
      logic st;
      assign d  = lane_dly(cfg_word_q, g);
      assign st = hist[d];
      dqs_gate_lane #(.BURST_Q(BURST_Q), .EXP_EDGES(EXP_EDGES), .TMO_Q(TMO_Q)) i_lane (
        .clk(clk), .rst_n(rst_n), .start(st), .active(cfg_act_q),
        .dqs(dqs_level[g]), .gate(gate_open[g])
      );
    end else begin : g_off
      assign gate_open[g] = 1'b0;
    end
  end

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(cfg_word_q) && $stable(cfg_act_q)));
  // R11
  cfg_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && !busy) |=> (cfg_act_q == $past(cfg_active_in)));
endmodule

// File: tb/test_dqs_gate_gen.sv
module test_dqs_gate_gen;
  localparam int NL  = 3;
  localparam int BQ  = 16;
  localparam int EXP = 7;
  localparam int TMO = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_issue = 1'b0;
  logic [31:0] cfg_word_in = '0;
  logic        cfg_active_in = 1'b0;
  logic        cfg_load = 1'b0;
  logic [NL-1:0] dqs_level = '0;
  logic [3:0]  gate_open;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dqs_gate_gen #(.NUM_LANES(NL), .BURST_Q(BQ), .EXP_EDGES(EXP), .TMO_Q(TMO)) i_dqs_gate_gen (
    .clk(clk), .rst_n(rst_n), .rd_issue(rd_issue), .cfg_word_in(cfg_word_in),
    .cfg_active_in(cfg_active_in), .cfg_load(cfg_load),
    .dqs_level(dqs_level), .gate_open(gate_open)
  );

  // reference model state
  int cyc = 0;
  int iss[64];
  int wp = 0;
  int last_iss = -100000;
  logic [31:0] m_word = '0;
  bit m_act = 0;
  bit eg[4];
  int ae[4], aq[4];
  bit pv[4];

  // stimulus schedule for active bursts
  bit act_phase = 0;
  int bstart[4];
  int npul[4];

  function automatic int dly_of(input logic [31:0] w, input int l);
    return int'((w >> (8 * l)) & 32'hFF);
  endfunction

  function automatic bit issued_at(input int t);
    for (int k = 0; k < 64; k++) if (iss[k] == t) return 1;
    return 0;
  endfunction

  // passive: open iff some issue i has n-16 < i+d <= n
  function automatic bit pas_window(input int n, input int d);
    for (int k = 0; k < BQ; k++) if (issued_at(n - d - k)) return 1;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc = 0; wp = 0; last_iss = -100000; m_word = '0; m_act = 0;
      for (int k = 0; k < 64; k++) iss[k] = -100000;
      for (int l = 0; l < 4; l++) begin eg[l] = 0; ae[l] = 0; aq[l] = 0; pv[l] = 0; end
    end else begin
      bit busy;
      cyc = cyc + 1;
      if (rd_issue) begin iss[wp] = cyc; wp = (wp + 1) % 64; last_iss = cyc; end
      busy = (cyc - last_iss <= 255);
      for (int l = 0; l < NL; l++) busy |= eg[l];
      for (int l = 0; l < NL; l++) begin
        int d; bit lv, r, f, st;
        d  = dly_of(m_word, l);
        lv = dqs_level[l];
        r  = lv & !pv[l];
        f  = !lv & pv[l];
        st = issued_at(cyc - d);
        if (!m_act) eg[l] = pas_window(cyc, d);
        else if (st) begin eg[l] = 1; ae[l] = 0; aq[l] = 0; end
        else if (eg[l]) begin
          if (f && ae[l] >= EXP) eg[l] = 0;
          else if (!(r || f) && aq[l] == TMO - 1) eg[l] = 0;
          else if (r || f) begin ae[l] = (ae[l] >= EXP) ? ae[l] : ae[l] + 1; aq[l] = 0; end
          else aq[l] = aq[l] + 1;
        end
        pv[l] = lv;
      end
      if (cfg_load && !busy) begin
        m_word = cfg_word_in; m_act = cfg_active_in;
        for (int k = 0; k < 64; k++) iss[k] = -100000;
      end
    end
  end

  task automatic check_gates();
    for (int l = 0; l < 4; l++) begin
      bit e;
      e = (l < NL) ? eg[l] : 1'b0;
      checks++;
      if (gate_open[l] !== e) begin
        fails++;
        if (l >= NL)
          $display("FAIL R9 lane %0d cyc %0d gate got %b exp %b", l, cyc, gate_open[l], e);
        else if (m_act)
          $display("FAIL R2 R3 R6 R7 R8 R11 lane %0d cyc %0d gate got %b exp %b", l, cyc, gate_open[l], e);
        else
          $display("FAIL R2 R3 R4 R5 R10 lane %0d cyc %0d gate got %b exp %b", l, cyc, gate_open[l], e);
      end
    end
  endtask

  // one cycle: check at negedge, then set DQS for the coming edge
  task automatic step();
    @(negedge clk);
    check_gates();
    for (int l = 0; l < NL; l++) begin
      if (act_phase) begin
        int rel;
        rel = cyc + 1 - bstart[l];
        dqs_level[l] = (rel >= 0 && rel < 4 * npul[l] && (rel % 4) < 2);
      end else begin
        dqs_level[l] = $urandom_range(1, 0);
      end
    end
  endtask

  task automatic do_read(input int np);
    rd_issue = 1'b1;
    for (int l = 0; l < NL; l++) begin
      bstart[l] = cyc + 1 + dly_of(m_word, l) + 2;
      npul[l] = np;
    end
    step();
    rd_issue = 1'b0;
  endtask

  task automatic load_cfg(input logic [31:0] w, input bit act);
    repeat (300) step();
    cfg_word_in = w; cfg_active_in = act; cfg_load = 1'b1;
    step();
    cfg_load = 1'b0;
    step();
  endtask

  task automatic try_bad_load();
    cfg_word_in = $urandom; cfg_active_in = $urandom_range(1, 0); cfg_load = 1'b1;
    step();
    cfg_load = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired at cyc %0d got running exp finished", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    for (int l = 0; l < 4; l++) begin bstart[l] = -1000; npul[l] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    checks++;
    if (gate_open !== 4'b0) begin
      fails++;
      $display("FAIL R1 reset gates got %b exp 0000", gate_open);
    end
    step();
    // R1 reset delays are zero: a read opens every lane on the same edge
    do_read(0);
    checks++;
    if (gate_open[NL-1:0] !== {NL{1'b1}}) begin
      fails++;
      $display("FAIL R1 R3 zero delay open got %b exp all ones", gate_open);
    end
    repeat (30) step();

    // directed passive: delays 0,1,255; back-to-back spacing 16 and 5
    load_cfg(32'h00FF_0100, 1'b0);
    do_read(0); repeat (15) step();
    do_read(0); repeat (4) step();
    do_read(0); try_bad_load(); repeat (40) step();
    try_bad_load();
    repeat (300) step();

    // random passive phase
    for (int p = 0; p < 3; p++) begin
      load_cfg($urandom, 1'b0);
      for (int k = 0; k < 60; k++) begin
        do_read(0);
        if ($urandom_range(7, 0) == 0) try_bad_load();
        repeat ($urandom_range(30, 8)) step();
      end
    end

    // active phase: delays kept small, full, short and restarted bursts
    load_cfg(32'h0000_3C00, 1'b1);
    act_phase = 1;
    do_read(4); repeat (120) step();
    do_read(2); repeat (120) step();
    do_read(0); repeat (120) step();
    for (int p = 0; p < 3; p++) begin
      act_phase = 0;
      load_cfg({8'h00, 8'($urandom_range(60, 0)), 8'($urandom_range(60, 0)), 8'($urandom_range(60, 0))}, 1'b1);
      act_phase = 1;
      for (int k = 0; k < 25; k++) begin
        int sel;
        sel = $urandom_range(5, 0);
        do_read(sel == 0 ? 1 : (sel == 1 ? 3 : 4));
        if (sel == 2) begin repeat (9) step(); do_read(4); end
        if ($urandom_range(5, 0) == 0) try_bad_load();
        repeat (110) step();
      end
    end
    act_phase = 0;
    repeat (20) step();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule